// File: doc/BRIEF.md
# Accumulating Xoroshiro32++ Random Word Generator

This block is a hardware pseudo-random number source. Its core is a 32-bit xoroshiro-style engine held as two 16-bit halves, s0 and s1. On every enabled cycle the engine advances twice, using two chained combinational step stages. The two "++" scrambler outputs form a 32-bit raw value: the first is the low half and the second is the high half.

The raw value is not emitted directly. A 32-bit feedback register mixes it with the previous result. The new low half is the raw low half XORed with the previous high half. The new high half is the raw high half plus the new low half plus one. The high half of that register is the single 16-bit word produced per step.

Software or a controller seeds the block through a 32-bit load port qualified by a strobe. It then requests words with a step enable and takes each word when the valid flag is high.

Top module: `xacc_gen`

## Requirements
- R1: While rst_ni is low, and after it rises with no other activity, valid_o is 0 and word_o is 0. Reset leaves the engine holding the substitute seed of R3.
- R2: When seed_valid_i is high in a cycle, the following happens at the next clock edge: s0 takes seed_i[15:0], s1 takes seed_i[31:16], the feedback register clears to zero, and valid_o is 0 in the following cycle. A seed load takes priority over a step in the same cycle.
- R3: A seed of all zeros is replaced by 32'h6A09_E667, which gives s1 = 16'h6A09 and s0 = 16'hE667. The engine state is never all zero.
- R4: One engine iteration computes sum = rotl(s0+s1, 9) + s0. It then sets t = s1 ^ s0, s0' = rotl(s0,13) ^ t ^ (t<<5), and s1' = rotl(t,10), all modulo 2^16. An enabled cycle performs two iterations; the first sum is raw[15:0] and the second is raw[31:16].
- R5: On each step the new result low half equals raw[15:0] XOR the previous result high half.
- R6: On each step the new result high half equals raw[31:16] + new low half + 1 modulo 2^16. word_o shows that high half, and exactly one word is produced per step.
- R7: In a cycle with step_i and seed_valid_i both low, the engine state and feedback register hold, word_o keeps its value, and valid_o is 0 in the next cycle.
- R8: valid_o is 1 in exactly the cycle after each cycle with step_i high and seed_valid_i low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| seed_i | input | 32 | Seed value, {s1, s0} |
| seed_valid_i | input | 1 | Load seed_i and clear the feedback register |
| step_i | input | 1 | Advance the engine and the feedback register |
| word_o | output | 16 | High half of the feedback register |
| valid_o | output | 1 | word_o was produced by the previous cycle's step |

## Verification
The assertions take the step and seed strobes as cycle-level controls that may take any value in any cycle, including both high at once. They rely only on the inputs being known, never X, once reset is released. The stimulus changes inputs only on falling edges, so they are stable around every rising edge. It mixes long step bursts, single steps, idle gaps, back-to-back reloads, an all-zero seed and a seed coinciding with a step. A software model of the engine and the mixing equations predicts every word, and each expected word passes through a scoreboard queue.

// File: rtl/xacc_pkg.sv
package xacc_pkg;
  localparam int unsigned HALF_W    = 16;
  localparam int unsigned ROT_SUM   = 9;
  localparam int unsigned ROT_A     = 13;
  localparam int unsigned SHL_B     = 5;
  localparam int unsigned ROT_C     = 10;
  localparam logic [2*HALF_W-1:0] ZERO_SUB = 32'h6A09_E667;
endpackage

// File: rtl/xacc_state.sv
module xacc_state
  import xacc_pkg::*;
#(
  parameter int unsigned W = HALF_W,
  parameter logic [2*W-1:0] SUB_SEED = ZERO_SUB
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [2*W-1:0] seed_i,
  input  logic         adv_i,
  input  logic [W-1:0] nxt_s0_i,
  input  logic [W-1:0] nxt_s1_i,
  output logic [W-1:0] s0_o,
  output logic [W-1:0] s1_o
);
  logic [W-1:0] s0_q, s1_q;
  logic [2*W-1:0] seed_eff;

  assign seed_eff = (seed_i == '0) ? SUB_SEED : seed_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s0_q <= SUB_SEED[W-1:0];
      s1_q <= SUB_SEED[2*W-1:W];
    end else if (load_i) begin
      s0_q <= seed_eff[W-1:0];
      s1_q <= seed_eff[2*W-1:W];
    end else if (adv_i) begin
      s0_q <= nxt_s0_i;
      s1_q <= nxt_s1_i;
    end
  end

  assign s0_o = s0_q;
  assign s1_o = s1_q;

  p_state_nonzero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {s1_q, s0_q} != '0);
  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !adv_i) |=> ($stable(s0_q) && $stable(s1_q)));
  p_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && seed_i != '0) |=> ({s1_q, s0_q} == $past(seed_i)));
endmodule

// File: rtl/xacc_engine_step.sv
module xacc_engine_step
  import xacc_pkg::*;
#(
  parameter int unsigned W     = HALF_W,
  parameter int unsigned R_SUM = ROT_SUM,
  parameter int unsigned R_A   = ROT_A,
  parameter int unsigned S_B   = SHL_B,
  parameter int unsigned R_C   = ROT_C
) (
  input  logic [W-1:0] s0_i,
  input  logic [W-1:0] s1_i,
  output logic [W-1:0] s0_o,
  output logic [W-1:0] s1_o,
  output logic [W-1:0] sum_o
);
  logic [W-1:0] add_v, rot_add, mix_t;

  always_comb begin
    add_v   = s0_i + s1_i;
    rot_add = (add_v << R_SUM) | (add_v >> (W - R_SUM));
    sum_o   = rot_add + s0_i;
    mix_t   = s1_i ^ s0_i;
    s0_o    = ((s0_i << R_A) | (s0_i >> (W - R_A))) ^ mix_t ^ (mix_t << S_B);
    s1_o    = (mix_t << R_C) | (mix_t >> (W - R_C));
  end
endmodule

// File: rtl/xacc_mix.sv
module xacc_mix
  import xacc_pkg::*;
#(
  parameter int unsigned W = HALF_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           clr_i,
  input  logic           step_i,
  input  logic [2*W-1:0] raw_i,
  output logic [2*W-1:0] res_o
);
  logic [2*W-1:0] res_q;
  logic [W-1:0]   lo_n, hi_n;

  always_comb begin
    lo_n = raw_i[W-1:0] ^ res_q[2*W-1:W];
    hi_n = raw_i[2*W-1:W] + lo_n + W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     res_q <= '0;
    else if (clr_i)  res_q <= '0;
    else if (step_i) res_q <= {hi_n, lo_n};
  end

  assign res_o = res_q;

  p_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (res_q == '0));
  p_hi_sum_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !clr_i) |=> (res_q[2*W-1:W] == W'($past(raw_i[2*W-1:W]) + res_q[W-1:0] + W'(1))));
  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !clr_i) |=> $stable(res_q));
endmodule

// File: rtl/xacc_gen.sv
module xacc_gen
  import xacc_pkg::*;
#(
  parameter int unsigned W     = HALF_W,
  parameter int unsigned ITERS = 2,
  localparam int unsigned RAW_W = 2 * W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [RAW_W-1:0] seed_i,
  input  logic             seed_valid_i,
  input  logic             step_i,
  output logic [W-1:0]     word_o,
  output logic             valid_o
);
  logic [W-1:0] st0 [ITERS+1];
  logic [W-1:0] st1 [ITERS+1];
  logic [W-1:0] sums [ITERS];
  logic [RAW_W-1:0] raw, res;
  logic adv, valid_q;

  assign adv = step_i && !seed_valid_i;

  xacc_state #(.W(W)) u_state (
    .clk_i, .rst_ni,
    .load_i  (seed_valid_i),
    .seed_i  (seed_i),
    .adv_i   (adv),
    .nxt_s0_i(st0[ITERS]),
    .nxt_s1_i(st1[ITERS]),
    .s0_o    (st0[0]),
    .s1_o    (st1[0])
  );

  for (genvar g = 0; g < ITERS; g++) begin : g_iter
    xacc_engine_step #(.W(W)) u_step (
      .s0_i (st0[g]),
      .s1_i (st1[g]),
      .s0_o (st0[g+1]),
      .s1_o (st1[g+1]),
      .sum_o(sums[g])
    );
  end

  assign raw = {sums[1], sums[0]};

  xacc_mix #(.W(W)) u_mix (
    .clk_i, .rst_ni,
    .clr_i (seed_valid_i),
    .step_i(adv),
    .raw_i (raw),
    .res_o (res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= 1'b0;
    else         valid_q <= adv;
  end

  assign word_o  = res[RAW_W-1:W];
  assign valid_o = valid_q;

  p_seed_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seed_valid_i |=> (!valid_o && word_o == '0));
  p_step_valid_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !seed_valid_i) |=> valid_o);
  p_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !seed_valid_i) |=> (!valid_o && $stable(word_o)));
endmodule

// File: tb/tb_xacc_gen.sv
module tb_xacc_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] seed = '0;
  logic seed_v = 1'b0, step = 1'b0;
  logic [15:0] word;
  logic valid;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [15:0] m0, m1, mres_lo, mres_hi, last_exp;
  logic [15:0] q[$];
  logic exp_v, exp_clr;

  always #10 clk = ~clk;

  xacc_gen dut (
    .clk_i(clk), .rst_ni(rst_n), .seed_i(seed), .seed_valid_i(seed_v),
    .step_i(step), .word_o(word), .valid_o(valid)
  );

  function automatic logic [15:0] rl(input logic [15:0] x, input int r);
    return 16'((x << r) | (x >> (16 - r)));
  endfunction

  // one model iteration (R4): returns sum, updates m0/m1
  function automatic logic [15:0] model_iter();
    logic [15:0] s, t;
    s  = rl(16'(m0 + m1), 9) + m0;
    t  = m1 ^ m0;
    m0 = rl(m0, 13) ^ t ^ 16'(t << 5);
    m1 = rl(t, 10);
    return s;
  endfunction

  task automatic drive(input bit st, input bit sv, input logic [31:0] sd);
    logic [15:0] r_lo, r_hi;
    @(negedge clk);
    step = st; seed_v = sv; seed = sd;
    if (sv) begin
      if (sd == 32'd0) begin m1 = 16'h6A09; m0 = 16'hE667; end
      else begin m1 = sd[31:16]; m0 = sd[15:0]; end
      mres_lo = '0; mres_hi = '0;
    end else if (st) begin
      r_lo = model_iter();
      r_hi = model_iter();
      mres_lo = r_lo ^ mres_hi;           // R5
      mres_hi = r_hi + mres_lo + 16'd1;   // R6
      q.push_back(mres_hi);
    end
  endtask

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin exp_v <= 1'b0; exp_clr <= 1'b0; end
    else begin
      exp_v   <= step && !seed_v;
      exp_clr <= seed_v;
    end
  end

  // monitor: scoreboard pop and compare
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(exp_v ? "R8 valid after step" : "R7 valid low when idle", 16'(valid), 16'(exp_v));
      if (exp_v) begin
        if (q.size() == 0) check("R6 unexpected word", word, 16'hxxxx);
        else begin
          last_exp = q.pop_front();
          check("R4 R5 R6 word", word, last_exp);
        end
      end else if (exp_clr) begin
        last_exp = '0;
        check("R2 cleared after seed", word, 16'h0000);
      end else begin
        check("R7 word holds", word, last_exp);
      end
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    m1 = 16'h6A09; m0 = 16'hE667; mres_lo = '0; mres_hi = '0; last_exp = '0;
    repeat (3) @(negedge clk);
    check("R1 reset valid", 16'(valid), 16'h0000);
    check("R1 reset word", word, 16'h0000);
    rst_n = 1'b1;
    drive(0, 0, '0);
    // R1: run from reset state without seeding
    for (int i = 0; i < 5; i++) drive(1, 0, '0);
    drive(0, 0, '0);
    // R2: normal seed then bursts and gaps
    drive(0, 1, 32'h1234_5678);
    for (int i = 0; i < 40; i++) drive(1, 0, '0);
    for (int i = 0; i < 20; i++) drive(i % 3 == 0, 0, '0);
    // R3: zero seed substituted
    drive(0, 1, 32'h0000_0000);
    for (int i = 0; i < 30; i++) drive(1, 0, '0);
    // R2: seed and step together, seed wins
    drive(1, 1, 32'hFFFF_FFFF);
    for (int i = 0; i < 25; i++) drive(i % 2, 0, '0);
    // back-to-back reloads
    drive(0, 1, 32'h0001_0000);
    drive(0, 1, 32'h0000_0001);
    for (int i = 0; i < 300; i++) drive(1, 0, '0);
    drive(0, 1, 32'hDEAD_BEEF);
    for (int i = 0; i < 50; i++) drive((i % 5) != 4, 0, '0);
    repeat (4) drive(0, 0, '0);
    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R6 words missing actual %0d expected 0", q.size());
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule